// File: doc/BRIEF.md
# Descriptor Poll Scheduler

This block decides when a network controller looks at its descriptor rings for new work. A programmable interval counter runs while the block is idle. When it expires, or when software asks for a demand poll, the block runs one poll. A poll first checks the receive ring and then checks the transmit ring. If the transmit check finds a descriptor held by the controller, the block raises a one-cycle start-transmit pulse and waits for the transmit operation to finish. If not, it goes back to idle and counts again.

The receive side of a poll is needed only while the controller does not yet hold both the current and the following receive descriptor. When the receive ring has a single entry, there is no following descriptor to look at. When a transmit operation ends, a new poll begins on the next cycle without waiting for the interval, so frames that are queued go out back to back. Reading descriptor fields and moving data belong to a separate descriptor engine. The scheduler talks to that engine through two request/acknowledge pairs, and the engine returns an ownership result together with each acknowledge.

Top module: `descPollSched`

## Requirements
- R1: While reset is low, and on the first cycle after it is released, rxChkReq, txChkReq and txStart are low and the interval count is zero.
- R2: While the block is idle, the count rises by one each cycle. A poll begins on the cycle after the count reaches or passes pollInterval, and the count then restarts at zero. With no demand, a transmit check that is acknowledged at once and not owned, and the receive side disabled, transmit checks start every pollInterval+2 cycles.
- R3: A demandPoll seen while idle makes the check requests of a poll appear on the next cycle and restarts the count. A demandPoll seen during a poll or a transmission is held, and a poll runs on the cycle after the block returns to idle.
- R4: With receive enabled and the current receive descriptor not held (rxCurOwned=0), a poll first asks for a check with rxChkSel=0 (current). Any transmit check comes after the receive checks of the same poll.
- R5: A check with rxChkSel=1 (next) is requested when the current descriptor is held and the next is not (rxNextOwned=0). The current descriptor counts as held if rxCurOwned was already 1 or if the current check returned rxChkOwned=1. When both are already held, the poll makes no receive check.
- R6: When rxRingIsOne=1, no check with rxChkSel=1 is ever requested.
- R7: With rxEnable=0 a poll makes no receive check, and with txEnable=0 it makes no transmit check.
- R8: A transmit check acknowledged with txChkOwned=0 returns the block to idle with the count at zero and no txStart.
- R9: A transmit check acknowledged with txChkOwned=1 gives a one-cycle txStart on the next cycle. No check request is raised after that until txDone.
- R10: A txDone during a transmission starts a poll on the next cycle, whatever the interval count.
- R11: A request stays high with rxChkSel unchanged until it is acknowledged, and rxChkReq and txChkReq are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pollInterval | input | CNT_W | Terminal value of the idle interval count |
| demandPoll | input | 1 | Request for an immediate poll |
| rxEnable | input | 1 | Receive side enabled |
| txEnable | input | 1 | Transmit side enabled |
| rxCurOwned | input | 1 | Controller already holds the current receive descriptor |
| rxNextOwned | input | 1 | Controller already holds the next receive descriptor |
| rxRingIsOne | input | 1 | Receive ring has a single entry |
| txDone | input | 1 | Pulse: the transmit operation has finished, including status updates |
| rxChkReq | output | 1 | Ask the engine to check a receive descriptor |
| rxChkSel | output | 1 | Which receive descriptor: 0 current, 1 next |
| rxChkAck | input | 1 | Engine finished the receive check |
| rxChkOwned | input | 1 | With rxChkAck: the checked descriptor is now held |
| txChkReq | output | 1 | Ask the engine to check the next transmit descriptor |
| txChkAck | input | 1 | Engine finished the transmit check |
| txChkOwned | input | 1 | With txChkAck: the transmit descriptor is held |
| txStart | output | 1 | One-cycle pulse: begin filling the FIFO and transmitting |

## Verification
On every cycle the assertions check the handshake rules: requests stay high until acknowledged, the two requests are never high together, and a next-descriptor check never appears for a single-entry ring. They also check that a receive check never begins while receive is disabled, and that txStart is a single pulse caused by an owned transmit acknowledge and followed by quiet. Interval timing, the hold of a demand poll that arrives mid-poll, the order of receive and transmit checks within a poll, and the one-cycle gap from txDone to the next poll are cycle counts over whole sequences. Only the bench scenarios, compared against the reference model, can show those.

// File: rtl/pollSchedPkg.sv
package pollSchedPkg;

  typedef enum logic [2:0] {
    PS_IDLE,
    PS_RXCUR,
    PS_RXNXT,
    PS_TXCHK,
    PS_TXRUN
  } pollStateT;

  // Strobes from the sequencer into the counter datapath
  typedef struct packed {
    logic cntInc;
    logic cntClear;
    logic pendClear;
    logic txStartSet;
  } pollStrobeT;

endpackage

// File: rtl/pollSchedDatapath.sv
module pollSchedDatapath
  import pollSchedPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] pollInterval,
  input  logic             demandPoll,
  input  pollStrobeT       strobe,
  output logic             intervalUp,
  output logic             pendingPoll,
  output logic             txStart
);

  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.cntClear) begin
      cntQ <= '0;
    end else if (strobe.cntInc) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  // Comparing with >= keeps a lowered interval from wrapping the count
  assign intervalUp = (cntQ >= pollInterval);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingPoll <= 1'b0;
    end else if (strobe.pendClear) begin
      pendingPoll <= 1'b0;
    end else if (demandPoll) begin
      pendingPoll <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txStart <= 1'b0;
    end else begin
      txStart <= strobe.txStartSet;
    end
  end

endmodule

// File: rtl/pollSchedControl.sv
module pollSchedControl
  import pollSchedPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxEnable,
  input  logic       txEnable,
  input  logic       rxCurOwned,
  input  logic       rxNextOwned,
  input  logic       rxRingIsOne,
  input  logic       txDone,
  input  logic       demandPoll,
  input  logic       intervalUp,
  input  logic       pendingPoll,
  input  logic       rxChkAck,
  input  logic       rxChkOwned,
  input  logic       txChkAck,
  input  logic       txChkOwned,
  output pollStrobeT strobe,
  output logic       rxChkReq,
  output logic       rxChkSel,
  output logic       txChkReq
);

  pollStateT stQ, stNext, entryState, afterRx;
  logic needNext;

  always_ff @(posedge clk) begin
    if (!rstN) stQ <= PS_IDLE;
    else       stQ <= stNext;
  end

  // First step of a new poll
  always_comb begin
    entryState = PS_IDLE;
    if (rxEnable && !rxCurOwned)
      entryState = PS_RXCUR;
    else if (rxEnable && rxCurOwned && !rxRingIsOne && !rxNextOwned)
      entryState = PS_RXNXT;
    else if (txEnable)
      entryState = PS_TXCHK;
  end

  assign afterRx  = txEnable ? PS_TXCHK : PS_IDLE;
  assign needNext = rxChkOwned && !rxRingIsOne && !rxNextOwned;

  always_comb begin
    stNext = stQ;
    strobe = '0;
    unique case (stQ)
      PS_IDLE: begin
        if (demandPoll || pendingPoll || intervalUp) begin
          stNext           = entryState;
          strobe.cntClear  = 1'b1;
          strobe.pendClear = 1'b1;
        end else begin
          strobe.cntInc = 1'b1;
        end
      end
      PS_RXCUR: if (rxChkAck) stNext = needNext ? PS_RXNXT : afterRx;
      PS_RXNXT: if (rxChkAck) stNext = afterRx;
      PS_TXCHK: begin
        if (txChkAck) begin
          if (txChkOwned) begin
            stNext            = PS_TXRUN;
            strobe.txStartSet = 1'b1;
          end else begin
            stNext = PS_IDLE;
          end
        end
      end
      PS_TXRUN: begin
        if (txDone) begin
          stNext           = entryState;
          strobe.cntClear  = 1'b1;
          strobe.pendClear = 1'b1;
        end
      end
      default: stNext = PS_IDLE;
    endcase
  end

  assign rxChkReq = (stQ == PS_RXCUR) || (stQ == PS_RXNXT);
  assign rxChkSel = (stQ == PS_RXNXT);
  assign txChkReq = (stQ == PS_TXCHK);

endmodule

// File: rtl/descPollSched.sv
module descPollSched
  import pollSchedPkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] pollInterval,
  input  logic             demandPoll,
  input  logic             rxEnable,
  input  logic             txEnable,
  input  logic             rxCurOwned,
  input  logic             rxNextOwned,
  input  logic             rxRingIsOne,
  input  logic             txDone,
  output logic             rxChkReq,
  output logic             rxChkSel,
  input  logic             rxChkAck,
  input  logic             rxChkOwned,
  output logic             txChkReq,
  input  logic             txChkAck,
  input  logic             txChkOwned,
  output logic             txStart
);

  pollStrobeT strobe;
  logic intervalUp;
  logic pendingPoll;

  pollSchedControl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rxEnable   (rxEnable),
    .txEnable   (txEnable),
    .rxCurOwned (rxCurOwned),
    .rxNextOwned(rxNextOwned),
    .rxRingIsOne(rxRingIsOne),
    .txDone     (txDone),
    .demandPoll (demandPoll),
    .intervalUp (intervalUp),
    .pendingPoll(pendingPoll),
    .rxChkAck   (rxChkAck),
    .rxChkOwned (rxChkOwned),
    .txChkAck   (txChkAck),
    .txChkOwned (txChkOwned),
    .strobe     (strobe),
    .rxChkReq   (rxChkReq),
    .rxChkSel   (rxChkSel),
    .txChkReq   (txChkReq)
  );

  pollSchedDatapath #(.CNT_W(CNT_W)) uData (
    .clk         (clk),
    .rstN        (rstN),
    .pollInterval(pollInterval),
    .demandPoll  (demandPoll),
    .strobe      (strobe),
    .intervalUp  (intervalUp),
    .pendingPoll (pendingPoll),
    .txStart     (txStart)
  );

endmodule

// File: rtl/descPollSchedChk.sv
module descPollSchedChk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] pollInterval,
  input logic             demandPoll,
  input logic             rxEnable,
  input logic             txEnable,
  input logic             rxCurOwned,
  input logic             rxNextOwned,
  input logic             rxRingIsOne,
  input logic             txDone,
  input logic             rxChkReq,
  input logic             rxChkSel,
  input logic             rxChkAck,
  input logic             rxChkOwned,
  input logic             txChkReq,
  input logic             txChkAck,
  input logic             txChkOwned,
  input logic             txStart
);

  a_r11_one_req: assert property (@(posedge clk) disable iff (!rstN)
    !(rxChkReq && txChkReq));

  a_r11_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxChkReq && !rxChkAck) |=> (rxChkReq && $stable(rxChkSel)));

  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txChkReq && !txChkAck) |=> txChkReq);

  a_r6_ring_one: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxChkReq && rxChkSel) |-> !$past(rxRingIsOne));

  a_r7_rx_off: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxChkReq) |-> $past(rxEnable));

  a_r9_pulse: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);

  a_r9_cause: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> $past(txChkReq && txChkAck && txChkOwned));

  a_r9_quiet: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (!rxChkReq && !txChkReq));

endmodule

bind descPollSched descPollSchedChk #(.CNT_W(CNT_W)) uChk (.*);

// File: tb/tb_descPollSched.sv
module tb_descPollSched;

  localparam int CNT_W = 16;
  localparam int M_IDLE = 0, M_RXCUR = 1, M_RXNXT = 2, M_TXCHK = 3, M_TXRUN = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CNT_W-1:0] pollInterval = 16'd5;
  logic demandPoll = 0, rxEnable = 0, txEnable = 1;
  logic rxCurOwned = 0, rxNextOwned = 0, rxRingIsOne = 0, txDone = 0;
  logic rxChkReq, rxChkSel, txChkReq, txStart;
  logic rxChkAck = 0, rxChkOwned = 0, txChkAck = 0, txChkOwned = 0;

  always #2 clk = ~clk;

  descPollSched #(.CNT_W(CNT_W)) dut (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  int mSt = M_IDLE, mCnt = 0;
  bit mPend = 0, mTxStart = 0;

  function automatic int entryOf();
    if (rxEnable && !rxCurOwned) return M_RXCUR;
    if (rxEnable && rxCurOwned && !rxRingIsOne && !rxNextOwned) return M_RXNXT;
    if (txEnable) return M_TXCHK;
    return M_IDLE;
  endfunction

  always @(posedge clk) begin
    int nSt;
    bit nPend, nStart;
    nSt = mSt; nPend = mPend | demandPoll; nStart = 0;
    if (!rstN) begin
      mSt = M_IDLE; mCnt = 0; mPend = 0; mTxStart = 0;
    end else begin
      case (mSt)
        M_IDLE:
          if (demandPoll || mPend || mCnt >= int'(pollInterval)) begin
            nSt = entryOf(); mCnt = 0; nPend = 0;
          end else mCnt++;
        M_RXCUR:
          if (rxChkAck) begin
            if (rxChkOwned && !rxRingIsOne && !rxNextOwned) nSt = M_RXNXT;
            else nSt = txEnable ? M_TXCHK : M_IDLE;
          end
        M_RXNXT:
          if (rxChkAck) nSt = txEnable ? M_TXCHK : M_IDLE;
        M_TXCHK:
          if (txChkAck) begin
            if (txChkOwned) begin nSt = M_TXRUN; nStart = 1; end
            else nSt = M_IDLE;
          end
        default:
          if (txDone) begin nSt = entryOf(); mCnt = 0; nPend = 0; end
      endcase
      mSt = nSt; mPend = nPend; mTxStart = nStart;
    end
  end

  // Engine responder, transmit-done driver, monitors, per-cycle compare
  int ackDelay = 0, waitCnt = 0, txLen = 4, txCnt = 0;
  bit curResult = 0, nextResult = 0, txResult = 0;
  int cycle = 0, nRxCur = 0, nRxNext = 0, nTxChk = 0, nTxStart = 0;
  int txRise = -1, txRisePrev = -1, rxRise = -1, doneCycle = -1;
  bit pCur = 0, pNext = 0, pTx = 0;

  always @(negedge clk) begin
    if (rstN) begin
      check(rxChkReq == (mSt == M_RXCUR || mSt == M_RXNXT), "R4 rxChkReq", rxChkReq, 0);
      check(rxChkSel == (mSt == M_RXNXT), "R5 rxChkSel", rxChkSel, mSt == M_RXNXT);
      check(txChkReq == (mSt == M_TXCHK), "R8 txChkReq", txChkReq, mSt == M_TXCHK);
      check(txStart == mTxStart, "R9 txStart", txStart, mTxStart);
    end
    if (rxChkReq && !rxChkSel && !pCur) begin nRxCur++; rxRise = cycle; end
    if (rxChkReq && rxChkSel && !pNext) begin nRxNext++; rxRise = cycle; end
    if (txChkReq && !pTx) begin nTxChk++; txRisePrev = txRise; txRise = cycle; end
    if (txStart) nTxStart++;
    pCur = rxChkReq && !rxChkSel; pNext = rxChkReq && rxChkSel; pTx = txChkReq;
    if (rxChkAck || txChkAck) begin
      rxChkAck = 0; txChkAck = 0; waitCnt = 0;
    end else if (rxChkReq) begin
      if (waitCnt >= ackDelay) begin
        rxChkAck = 1; rxChkOwned = rxChkSel ? nextResult : curResult;
      end else waitCnt++;
    end else if (txChkReq) begin
      if (waitCnt >= ackDelay) begin
        txChkAck = 1; txChkOwned = txResult;
      end else waitCnt++;
    end
    if (txDone) txDone = 0;
    else if (txStart) txCnt = txLen;
    else if (txCnt > 0) begin
      txCnt--;
      if (txCnt == 0) begin txDone = 1; doneCycle = cycle; end
    end
    cycle++;
  end

  task automatic pulseDemand();
    @(negedge clk); demandPoll = 1;
    @(negedge clk); demandPoll = 0;
  endtask

  initial begin
    int c0, n0, x0;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(!rxChkReq && !txChkReq && !txStart, "R1 outputs in reset", {rxChkReq, txChkReq, txStart}, 0);
    rstN = 1;
    @(negedge clk);
    check(!rxChkReq && !txChkReq && !txStart, "R1 outputs after release", {rxChkReq, txChkReq, txStart}, 0);

    // R2 / R8: periodic polls, transmit not owned
    repeat (40) @(negedge clk);
    check(txRise - txRisePrev == int'(pollInterval) + 2, "R2 poll period", txRise - txRisePrev, int'(pollInterval) + 2);
    check(nTxStart == 0, "R8 no start when not owned", nTxStart, 0);

    // R3: demand poll from idle and while busy
    pollInterval = 16'd1000;
    repeat (20) @(negedge clk);
    demandPoll = 1;
    @(negedge clk); demandPoll = 0;
    check(txChkReq == 1, "R3 demand poll next cycle", txChkReq, 1);
    repeat (10) @(negedge clk);
    ackDelay = 3; n0 = nTxChk;
    demandPoll = 1;
    repeat (2) @(negedge clk);
    demandPoll = 0;
    repeat (20) @(negedge clk);
    check(nTxChk == n0 + 2, "R3 demand held during poll", nTxChk - n0, 2);

    // R4 / R5: current then next then transmit
    ackDelay = 1; rxEnable = 1; curResult = 1; nextResult = 1;
    c0 = nRxCur; n0 = nRxNext; x0 = nTxChk;
    pulseDemand(); repeat (20) @(negedge clk);
    check(nRxCur == c0 + 1, "R4 current checked", nRxCur - c0, 1);
    check(nRxNext == n0 + 1, "R5 next checked after owned current", nRxNext - n0, 1);
    check(txRise > rxRise && nTxChk == x0 + 1, "R4 transmit after receive", txRise - rxRise, 1);

    // R6: ring of length one
    rxRingIsOne = 1; c0 = nRxCur; n0 = nRxNext;
    pulseDemand(); repeat (20) @(negedge clk);
    check(nRxCur == c0 + 1, "R6 current checked", nRxCur - c0, 1);
    check(nRxNext == n0, "R6 no next check", nRxNext - n0, 0);

    // R5: current already held
    rxRingIsOne = 0; rxCurOwned = 1; c0 = nRxCur; n0 = nRxNext;
    pulseDemand(); repeat (20) @(negedge clk);
    check(nRxCur == c0 && nRxNext == n0 + 1, "R5 skip current, check next", nRxNext - n0, 1);
    rxNextOwned = 1; c0 = nRxCur; n0 = nRxNext; x0 = nTxChk;
    pulseDemand(); repeat (20) @(negedge clk);
    check(nRxCur + nRxNext == c0 + n0, "R5 both held no rx check", nRxCur + nRxNext - c0 - n0, 0);
    check(nTxChk == x0 + 1, "R5 transmit still checked", nTxChk - x0, 1);

    // R7: enables
    rxCurOwned = 0; rxNextOwned = 0; rxEnable = 0;
    c0 = nRxCur; n0 = nRxNext; x0 = nTxChk;
    pulseDemand(); repeat (20) @(negedge clk);
    check(nRxCur + nRxNext == c0 + n0, "R7 rx disabled", nRxCur + nRxNext - c0 - n0, 0);
    check(nTxChk == x0 + 1, "R7 tx enabled checked", nTxChk - x0, 1);
    txEnable = 0; x0 = nTxChk;
    pulseDemand(); repeat (20) @(negedge clk);
    check(nTxChk == x0, "R7 tx disabled", nTxChk - x0, 0);

    // R9 / R10: owned transmit, back-to-back poll
    txEnable = 1; ackDelay = 0; txResult = 1; txLen = 6; n0 = nTxStart;
    pulseDemand();
    while (nTxStart == n0) @(negedge clk);
    txResult = 0;
    repeat (20) @(negedge clk);
    check(nTxStart == n0 + 1, "R9 single start pulse", nTxStart - n0, 1);
    check(txRise - doneCycle == 1, "R10 poll right after done", txRise - doneCycle, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycle, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule